// File: doc/BRIEF.md
# SDRAM Mode Register Controller

This block keeps the working configuration of a double-data-rate SDRAM-style memory. A mode-register-set strobe, qualified by two bank-select bits that are both zero, copies selected address lines into the register. The stored fields are then presented in decoded form: the burst length as a count of beats, the burst ordering, the read latency in half-clock units and the raw operating-mode bits. The configuration persists until the next accepted load or a reset.

A load is accepted only when all of these hold: every bank reports idle, no burst is running, the settle interval of a previous load has elapsed, and both the burst-length code and the latency code are supported. Any other load is dropped, the register is left unchanged, and a one-cycle error pulse is produced. An accepted load raises busy for a parameterised number of cycles, which tells the command sequencer to hold off. One operating-mode bit is self-clearing: it shows the written value for one cycle and then returns to zero.

Top module: `sdram_modereg_ctrl`

## Requirements
- R1: After reset the outputs read burst_len=2, burst_ilv=0, cas_x2=4, op_mode=0, load_err=0 and busy=0.
- R2: An accepted load takes effect in the cycle after the strobe. Burst-length codes on addr[2:0] decode as 001→2, 010→4 and 011→8. addr[3] gives burst_ilv (1 = interleaved). Latency codes on addr[6:4] decode as 010→cas_x2=4 and 110→cas_x2=5. op_mode takes addr[12:7].
- R3: A load carrying any other burst-length code or latency code pulses load_err for one cycle and leaves every stored field unchanged.
- R4: A load attempted while any bit of bank_idle is 0, or while burst_active is 1, pulses load_err for one cycle and leaves every stored field unchanged.
- R5: A strobe with ba not equal to 00 has no effect: no field changes, no error, no busy.
- R6: op_mode[1] (written from addr[8]) reads the written value for exactly the first cycle after an accepted load and reads 0 from then on.
- R7: An accepted load holds busy at 1 for exactly SETTLE cycles, starting the cycle after the strobe. Rejected loads do not start busy.
- R8: A load attempted while busy is 1 is rejected. It pulses load_err, leaves the fields unchanged and does not restart the busy interval.
- R9: With no strobe, all stored fields hold their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_cmd | input | 1 | Mode-register-set command strobe, one cycle per command |
| ba | input | 2 | Bank-select bits; a load needs 00 |
| addr | input | 13 | Address bus carrying the register fields |
| bank_idle | input | 4 | One bit per bank, 1 = bank idle |
| burst_active | input | 1 | 1 while a read or write burst is running |
| burst_len | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_ilv | output | 1 | 1 = interleaved ordering, 0 = sequential |
| cas_x2 | output | 3 | Read latency in half clocks (4 or 5) |
| op_mode | output | 6 | Operating-mode field; bit 1 self-clears |
| load_err | output | 1 | One-cycle pulse per rejected load |
| busy | output | 1 | Settle interval running; hold further commands |

## Verification
The assertions assume that mr_cmd is a single-cycle strobe per command. They also assume that bank_idle, burst_active and addr are sampled only in the cycle where the strobe is high. No assumption is made about their values at other times. The stimulus raises the strobe for one cycle per command and returns the other inputs to idle, benign values between commands. Back-to-back strobes are used on purpose, and only to exercise rejection during busy.

// File: rtl/sdram_mr_pkg.sv
package sdram_mr_pkg;

  typedef enum logic [2:0] {
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011
  } bl_code_e;

  typedef enum logic [2:0] {
    LAT_TWO      = 3'b010,
    LAT_TWO_HALF = 3'b110
  } lat_code_e;

  localparam int BL_LSB  = 0;
  localparam int ILV_BIT = 3;
  localparam int LAT_LSB = 4;
  localparam int OP_LSB  = 7;
  localparam int SCLR_BIT = 1;

  function automatic logic bl_supported(input logic [2:0] c);
    return (c == BL_TWO) || (c == BL_FOUR) || (c == BL_EIGHT);
  endfunction

  function automatic logic lat_supported(input logic [2:0] c);
    return (c == LAT_TWO) || (c == LAT_TWO_HALF);
  endfunction

  function automatic logic [3:0] bl_beats(input logic [2:0] c);
    logic [3:0] r;
    case (c)
      BL_FOUR:  r = 4'd4;
      BL_EIGHT: r = 4'd8;
      default:  r = 4'd2;
    endcase
    return r;
  endfunction

  function automatic logic [2:0] lat_halves(input logic [2:0] c);
    return (c == LAT_TWO_HALF) ? 3'd5 : 3'd4;
  endfunction

endpackage

// File: rtl/mr_field_decode.sv
module mr_field_decode
  import sdram_mr_pkg::*;
#(
  parameter int ADDR_W = 13,
  localparam int OP_W  = ADDR_W - OP_LSB
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        blen,
  output logic              ilv,
  output logic [2:0]        cas_x2,
  output logic [OP_W-1:0]   op,
  output logic              code_ok
);
  logic [2:0] bl_c;
  logic [2:0] lat_c;

  always_comb begin
    bl_c    = addr[BL_LSB +: 3];
    lat_c   = addr[LAT_LSB +: 3];
    blen    = bl_beats(bl_c);
    ilv     = addr[ILV_BIT];
    cas_x2  = lat_halves(lat_c);
    op      = addr[ADDR_W-1:OP_LSB];
    code_ok = bl_supported(bl_c) && lat_supported(lat_c);
  end
endmodule

// File: rtl/mr_load_guard.sv
module mr_load_guard #(
  parameter int NBANK = 4,
  parameter int BA_W  = 2
) (
  input  logic             cmd,
  input  logic [BA_W-1:0]  ba,
  input  logic [NBANK-1:0] bank_idle,
  input  logic             burst_active,
  input  logic             busy,
  input  logic             code_ok,
  output logic             take,
  output logic             reject
);
  logic sel;
  logic quiet;

  always_comb begin
    sel    = cmd && (ba == '0);
    quiet  = (&bank_idle) && !burst_active && !busy;
    take   = sel && quiet && code_ok;
    reject = sel && !(quiet && code_ok);
  end
endmodule

// File: rtl/mr_settle_timer.sv
module mr_settle_timer #(
  parameter int SETTLE = 2,
  localparam int CNT_W = $clog2(SETTLE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CNT_W'(SETTLE);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sdram_modereg_ctrl.sv
module sdram_modereg_ctrl
  import sdram_mr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int NBANK  = 4,
  parameter int BA_W   = 2,
  parameter int SETTLE = 2,
  localparam int OP_W  = ADDR_W - OP_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mr_cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bank_idle,
  input  logic              burst_active,
  output logic [3:0]        burst_len,
  output logic              burst_ilv,
  output logic [2:0]        cas_x2,
  output logic [OP_W-1:0]   op_mode,
  output logic              load_err,
  output logic              busy
);
  logic [3:0]      d_blen;
  logic            d_ilv;
  logic [2:0]      d_cas;
  logic [OP_W-1:0] d_op;
  logic            d_ok;
  logic            take;
  logic            reject;

  mr_field_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .blen(d_blen), .ilv(d_ilv), .cas_x2(d_cas),
    .op(d_op), .code_ok(d_ok)
  );

  mr_load_guard #(.NBANK(NBANK), .BA_W(BA_W)) u_guard (
    .cmd(mr_cmd), .ba(ba), .bank_idle(bank_idle),
    .burst_active(burst_active), .busy(busy), .code_ok(d_ok),
    .take(take), .reject(reject)
  );

  mr_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst(rst), .start(take), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len <= 4'd2;
      burst_ilv <= 1'b0;
      cas_x2    <= 3'd4;
      load_err  <= 1'b0;
    end else begin
      load_err <= reject;
      if (take) begin
        burst_len <= d_blen;
        burst_ilv <= d_ilv;
        cas_x2    <= d_cas;
      end
    end
  end

  // Operating-mode bits: the self-clearing position drops back to 0 one
  // cycle after it was written; the others simply hold.
  for (genvar i = 0; i < OP_W; i++) begin : g_op
    if (i == SCLR_BIT) begin : g_sclr
      always_ff @(posedge clk) begin
        if (rst)       op_mode[i] <= 1'b0;
        else if (take) op_mode[i] <= d_op[i];
        else           op_mode[i] <= 1'b0;
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)       op_mode[i] <= 1'b0;
        else if (take) op_mode[i] <= d_op[i];
      end
    end
  end
endmodule

// File: rtl/sdram_modereg_chk.sv
module sdram_modereg_chk #(
  parameter int ADDR_W = 13,
  parameter int NBANK  = 4,
  parameter int BA_W   = 2,
  parameter int SETTLE = 2,
  localparam int OP_W  = ADDR_W - 7,
  localparam int RUN_W = $clog2(SETTLE + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              mr_cmd,
  input logic [BA_W-1:0]   ba,
  input logic [NBANK-1:0]  bank_idle,
  input logic              burst_active,
  input logic [3:0]        burst_len,
  input logic              burst_ilv,
  input logic [2:0]        cas_x2,
  input logic [OP_W-1:0]   op_mode,
  input logic              load_err,
  input logic              busy
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R3 / R4 / R8: a rejected load leaves the stored fields as they were
  a_r3_err_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    load_err |-> ($stable(burst_len) && $stable(burst_ilv) && $stable(cas_x2)
                  && $stable(op_mode[OP_W-1:2]) && $stable(op_mode[0])));

  a_r4_bank_active_rejects: assert property (@(posedge clk) disable iff (rst)
    (mr_cmd && ba == '0 && (!(&bank_idle) || burst_active)) |=> load_err);

  a_r5_other_bank_quiet: assert property (@(posedge clk) disable iff (rst)
    (mr_cmd && ba != '0) |=> (!load_err && $stable(burst_len) && $stable(cas_x2)));

  a_r6_sclr_one_cycle: assert property (@(posedge clk) disable iff (rst)
    op_mode[1] |=> !op_mode[1]);

  a_r6_sclr_only_on_load: assert property (@(posedge clk) disable iff (rst)
    op_mode[1] |-> (busy && !load_err));

  a_r7_busy_window: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < RUN_W'(SETTLE)));

  a_r7_busy_starts_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !load_err);

  a_r8_busy_rejects: assert property (@(posedge clk) disable iff (rst)
    (mr_cmd && ba == '0 && busy) |=> load_err);

  a_r2_legal_values: assert property (@(posedge clk) disable iff (rst)
    ((burst_len == 4'd2 || burst_len == 4'd4 || burst_len == 4'd8)
     && (cas_x2 == 3'd4 || cas_x2 == 3'd5)));
endmodule

bind sdram_modereg_ctrl sdram_modereg_chk #(
  .ADDR_W(ADDR_W), .NBANK(NBANK), .BA_W(BA_W), .SETTLE(SETTLE)
) u_chk (
  .clk(clk), .rst(rst), .mr_cmd(mr_cmd), .ba(ba), .bank_idle(bank_idle),
  .burst_active(burst_active), .burst_len(burst_len), .burst_ilv(burst_ilv),
  .cas_x2(cas_x2), .op_mode(op_mode), .load_err(load_err), .busy(busy)
);

// File: tb/sdram_modereg_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_modereg_ctrl_bench;
  localparam int SETTLE = 2;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mr_cmd = 1'b0;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic [NB-1:0] bank_idle = '1;
  logic        burst_active = 1'b0;
  logic [3:0]  burst_len;
  logic        burst_ilv;
  logic [2:0]  cas_x2;
  logic [5:0]  op_mode;
  logic        load_err;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_bl = 2;
  int m_ilv = 0;
  int m_cas = 4;
  int m_op = 0;
  int m_err = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  sdram_modereg_ctrl #(.SETTLE(SETTLE)) u_sdram_modereg_ctrl (
    .clk(clk), .rst(rst), .mr_cmd(mr_cmd), .ba(ba), .addr(addr),
    .bank_idle(bank_idle), .burst_active(burst_active),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_x2(cas_x2),
    .op_mode(op_mode), .load_err(load_err), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "burst_len", int'(burst_len), m_bl);
    chk(req, "burst_ilv", int'(burst_ilv), m_ilv);
    chk(req, "cas_x2", int'(cas_x2), m_cas);
    chk(req, "op_mode", int'(op_mode), m_op);
    chk(req, "load_err", int'(load_err), m_err);
    chk(req, "busy", int'(busy), (m_cnt != 0) ? 1 : 0);
  endtask

  // one cycle without a command
  task automatic idle(input string req);
    @(negedge clk);
    m_op = m_op & ~2;
    m_err = 0;
    if (m_cnt > 0) m_cnt--;
    check_all(req);
  endtask

  task automatic settle_out(input string req);
    while (m_cnt != 0) idle(req);
    idle(req);
  endtask

  task automatic issue(input logic [1:0] b, input logic [12:0] a,
                       input logic [NB-1:0] idl, input logic bst, input string req);
    bit sel, okc, legal;
    int blc, latc;
    blc = int'(a[2:0]);
    latc = int'(a[6:4]);
    sel = (b == 2'b00);
    okc = (blc >= 1 && blc <= 3) && (latc == 2 || latc == 6);
    legal = sel && okc && (idl == '1) && !bst && (m_cnt == 0);
    mr_cmd = 1'b1; ba = b; addr = a; bank_idle = idl; burst_active = bst;
    @(negedge clk);
    mr_cmd = 1'b0; ba = 2'b00; addr = '0; bank_idle = '1; burst_active = 1'b0;
    m_err = (sel && !legal) ? 1 : 0;
    if (legal) begin
      m_bl = 1 << blc;
      m_ilv = int'(a[3]);
      m_cas = (latc == 6) ? 5 : 4;
      m_op = int'(a[12:7]);
      m_cnt = SETTLE;
    end else begin
      m_op = m_op & ~2;
      if (m_cnt > 0) m_cnt--;
    end
    check_all(req);
  endtask

  function automatic logic [12:0] mk(input int op, input int lat, input int ilv, input int bl);
    return {op[5:0], lat[2:0], ilv[0], bl[2:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    @(negedge clk);

    // R2 / R3 / R6 / R7: every burst code, latency code and ordering
    for (int bl = 0; bl < 8; bl++) begin
      for (int lat = 0; lat < 8; lat++) begin
        for (int iv = 0; iv < 2; iv++) begin
          issue(2'b00, mk((bl * 8 + lat + iv * 5) % 64, lat, iv, bl), '1, 1'b0, "R2_R3");
          settle_out("R7_R6");
        end
      end
    end

    // R6: self-clearing bit written as 1
    issue(2'b00, mk(6'b101011, 6, 1, 3), '1, 1'b0, "R6");
    chk("R6", "sclr set", int'(op_mode[1]), 1);
    idle("R6");
    chk("R6", "sclr cleared", int'(op_mode[1]), 0);
    settle_out("R6");

    // R4: each bank busy in turn, then a running burst
    for (int k = 0; k < NB; k++) begin
      issue(2'b00, mk(6'h15, 2, 0, 2), ~(NB'(1) << k), 1'b0, "R4");
      idle("R4");
    end
    issue(2'b00, mk(6'h15, 2, 0, 2), '1, 1'b1, "R4");
    idle("R4");

    // R5: other bank-select values
    for (int b = 1; b < 4; b++) begin
      issue(2'(b), mk(6'h3f, 2, 0, 1), '1, 1'b0, "R5");
      idle("R5");
    end

    // R8: back-to-back loads; second is rejected while busy
    issue(2'b00, mk(6'h02, 2, 0, 1), '1, 1'b0, "R8");
    issue(2'b00, mk(6'h30, 6, 1, 3), '1, 1'b0, "R8");
    settle_out("R8");

    // R9: long hold without commands
    repeat (20) idle("R9");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule